// File: doc/BRIEF.md
# Doorbell-Captured Message Interrupt Controller

This block turns message-signalled interrupt writes into a single level interrupt. Software programs a 64-bit doorbell address through a small 32-bit register port. Any inbound write that lands in the 4-byte window starting at that address, and that is a full-width access, is taken as an interrupt message. The data of such a write is a vector number N, and the write sets pending bit N when vector N is enabled.

Pending bits collect in a status register. The interrupt line is high whenever some pending bit has a clear mask bit. Software clears pending bits by writing ones to the status register, because each written one inverts its bit. The enable register decides whether a message is captured at all, and it also switches the doorbell decoder on or off as a whole. The mask register only gates the output line. Inbound traffic that is not a doorbell write, such as reads and partial writes, passes by with no effect.

Top module: `msi_doorbell_irq`

## Requirements
- R1: The register port decodes five 32-bit words by byte offset: doorbell address bits 31:0 at 0x820, doorbell address bits 63:32 at 0x824, vector enable at 0x828, vector mask at 0x82C and pending status at 0x830. The doorbell address, enable and mask read back as written, and any other offset reads as zero.
- R2: A doorbell write with data N below 32 sets status bit N when enable bit N is 1. When enable bit N is 0, status does not change.
- R3: `irq_o` equals the OR over all vectors of (status AND NOT mask). It changes after the same clock edge that updates status or mask, so masking or clearing the last active bit lowers it at that edge.
- R4: A register write to the status word inverts every status bit whose write-data bit is 1 and leaves the others unchanged.
- R5: While the enable register is all zeros, no inbound write is captured.
- R6: The doorbell window is the four byte addresses from the programmed 64-bit address to that address plus 3. Addresses outside the window are not captured, and this includes addresses that differ only in the upper 32 bits.
- R7: An inbound write whose four byte enables are not all 1 is not captured.
- R8: An inbound read (`in_is_wr_i` = 0) to the doorbell address has no effect on status.
- R9: A doorbell write whose data value is 32 or greater has no effect on status.
- R10: Reset sets the doorbell address, enable, mask and status to zero and holds `irq_o` low.
- R11: When a status register write and a captured doorbell write occur in the same cycle, the toggle is applied first and the captured bit is then set, so the captured bit always ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register port write strobe |
| reg_addr_i | input | 12 | Register port byte offset |
| reg_wdata_i | input | 32 | Register port write data |
| reg_rdata_o | output | 32 | Register port read data, combinational from reg_addr_i |
| in_vld_i | input | 1 | Inbound transaction valid |
| in_is_wr_i | input | 1 | Inbound transaction is a write (1) or a read (0) |
| in_addr_i | input | 64 | Inbound byte address |
| in_be_i | input | 4 | Inbound byte enables |
| in_data_i | input | 32 | Inbound write data, the vector number |
| irq_o | output | 1 | Level interrupt output |

## Verification
Doorbell messages are sent with vectors that are enabled and vectors that are not, and with data values at 31, 32 and far above 32. This separates the gating by enable from the range check on the vector number. Addresses at the first and last byte of the window, one byte on each side of it, and one with only the upper word changed show whether the 64-bit window compare is exact. Partial byte enables, reads, and an enable register of all zeros each probe one path that must stay inert. Mask changes, status toggles on set and clear bits, and a toggle in the same cycle as a capture show that the line follows status and mask, and that the capture takes precedence.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

   // Word index of each register relative to the register base offset.
   // Software decodes these positions, so the order is fixed.
   typedef enum logic [2:0] {
      WI_DB_LO = 3'd0,
      WI_DB_HI = 3'd1,
      WI_EN    = 3'd2,
      WI_MASK  = 3'd3,
      WI_STAT  = 3'd4
   } reg_idx_e;

   localparam int unsigned NUM_REG_WORDS = 5;

endpackage

// File: rtl/msi_reg_bank.sv
module msi_reg_bank
   import msi_cap_pkg::*;
#(
   parameter int unsigned REG_AW   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned NUM_VEC  = 32,
   parameter logic [REG_AW-1:0] REG_BASE = 12'h820
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_i,
   input  logic [REG_AW-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NUM_VEC-1:0] status_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic [ADDR_W-1:0]  db_base_o,
   output logic [NUM_VEC-1:0] enable_o,
   output logic [NUM_VEC-1:0] mask_o,
   output logic               stat_wr_o
);

   localparam int unsigned BYTE_SH = $clog2(DATA_W / 8);

   logic [REG_AW-1:0] rel;
   logic              in_rng;
   reg_idx_e          widx;
   logic [DATA_W-1:0] base_lo_q, base_hi_q;
   logic [NUM_VEC-1:0] en_q, mask_q;

   assign rel    = addr_i - REG_BASE;
   assign in_rng = (addr_i >= REG_BASE)
                   && (rel[BYTE_SH-1:0] == '0)
                   && (rel[REG_AW-1:BYTE_SH] < (REG_AW-BYTE_SH)'(NUM_REG_WORDS));
   assign widx   = reg_idx_e'(rel[BYTE_SH+2:BYTE_SH]);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         base_lo_q <= '0;
         base_hi_q <= '0;
         en_q      <= '0;
         mask_q    <= '0;
      end else if (wr_i && in_rng) begin
         case (widx)
            WI_DB_LO: base_lo_q <= wdata_i;
            WI_DB_HI: base_hi_q <= wdata_i;
            WI_EN:    en_q      <= wdata_i[NUM_VEC-1:0];
            WI_MASK:  mask_q    <= wdata_i[NUM_VEC-1:0];
            default:  ;
         endcase
      end
   end

   assign stat_wr_o = wr_i && in_rng && (widx == WI_STAT);

   always_comb begin
      rdata_o = '0;
      if (in_rng) begin
         case (widx)
            WI_DB_LO: rdata_o = base_lo_q;
            WI_DB_HI: rdata_o = base_hi_q;
            WI_EN:    rdata_o = DATA_W'(en_q);
            WI_MASK:  rdata_o = DATA_W'(mask_q);
            WI_STAT:  rdata_o = DATA_W'(status_i);
            default:  rdata_o = '0;
         endcase
      end
   end

   assign db_base_o = {base_hi_q, base_lo_q};
   assign enable_o  = en_q;
   assign mask_o    = mask_q;

endmodule

// File: rtl/msi_door_match.sv
module msi_door_match #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_VEC = 32
) (
   input  logic                vld_i,
   input  logic                is_wr_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W/8-1:0] be_i,
   input  logic [DATA_W-1:0]   data_i,
   input  logic [ADDR_W-1:0]   base_i,
   input  logic [NUM_VEC-1:0]  enable_i,
   output logic [NUM_VEC-1:0]  set_o
);

   localparam int unsigned BE_W = DATA_W / 8;

   logic [ADDR_W-1:0] offs;
   logic              fire;

   // Window of BE_W bytes from the base; the unsigned difference wraps
   // for addresses below the base, so one compare covers both sides.
   assign offs = addr_i - base_i;
   assign fire = vld_i && is_wr_i && (&be_i) && (|enable_i)
                 && (offs < ADDR_W'(BE_W));

   // Full-width compare of the data against each vector index also
   // rejects any value at or above NUM_VEC.
   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      assign set_o[v] = fire && enable_i[v] && (data_i == DATA_W'(v));
   end

endmodule

// File: rtl/msi_status_acc.sv
module msi_status_acc #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_VEC = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               stat_wr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NUM_VEC-1:0] set_i,
   input  logic [NUM_VEC-1:0] mask_i,
   output logic [NUM_VEC-1:0] status_o,
   output logic               irq_o
);

   logic [NUM_VEC-1:0] status_q, toggled;
   logic               pend;

   assign toggled = stat_wr_i ? (status_q ^ wdata_i[NUM_VEC-1:0]) : status_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) status_q <= '0;
      else         status_q <= toggled | set_i;
   end

   assign pend     = |(status_q & ~mask_i);
   assign status_o = status_q;

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= pend;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = pend;
   end

endmodule

// File: rtl/msi_doorbell_irq.sv
module msi_doorbell_irq #(
   parameter int unsigned REG_AW   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned NUM_VEC  = 32,
   parameter logic [REG_AW-1:0] REG_BASE = 12'h820,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                reg_wr_i,
   input  logic [REG_AW-1:0]   reg_addr_i,
   input  logic [DATA_W-1:0]   reg_wdata_i,
   output logic [DATA_W-1:0]   reg_rdata_o,
   input  logic                in_vld_i,
   input  logic                in_is_wr_i,
   input  logic [ADDR_W-1:0]   in_addr_i,
   input  logic [DATA_W/8-1:0] in_be_i,
   input  logic [DATA_W-1:0]   in_data_i,
   output logic                irq_o
);

   if (ADDR_W != 2 * DATA_W) begin : g_bad_addr_w
      $error("doorbell address must span exactly two register words");
   end
   if (NUM_VEC > DATA_W || NUM_VEC < 2) begin : g_bad_num_vec
      $error("vector count must fit one register word");
   end
   if (DATA_W % 8 != 0) begin : g_bad_data_w
      $error("data width must be whole bytes");
   end

   logic [ADDR_W-1:0]  db_base;
   logic [NUM_VEC-1:0] enable, mask, status_q, set_vec;
   logic               stat_wr;

   msi_reg_bank #(
      .REG_AW  (REG_AW),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .NUM_VEC (NUM_VEC),
      .REG_BASE(REG_BASE)
   ) regs_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (reg_wr_i),
      .addr_i   (reg_addr_i),
      .wdata_i  (reg_wdata_i),
      .status_i (status_q),
      .rdata_o  (reg_rdata_o),
      .db_base_o(db_base),
      .enable_o (enable),
      .mask_o   (mask),
      .stat_wr_o(stat_wr)
   );

   msi_door_match #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .NUM_VEC(NUM_VEC)
   ) match_i (
      .vld_i   (in_vld_i),
      .is_wr_i (in_is_wr_i),
      .addr_i  (in_addr_i),
      .be_i    (in_be_i),
      .data_i  (in_data_i),
      .base_i  (db_base),
      .enable_i(enable),
      .set_o   (set_vec)
   );

   msi_status_acc #(
      .DATA_W (DATA_W),
      .NUM_VEC(NUM_VEC),
      .IRQ_REG(IRQ_REG)
   ) stat_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .stat_wr_i(stat_wr),
      .wdata_i  (reg_wdata_i),
      .set_i    (set_vec),
      .mask_i   (mask),
      .status_o (status_q),
      .irq_o    (irq_o)
   );

endmodule

// File: rtl/msi_doorbell_irq_chk.sv
module msi_doorbell_irq_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_VEC = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic [NUM_VEC-1:0]  status,
   input logic [NUM_VEC-1:0]  enable,
   input logic [NUM_VEC-1:0]  mask,
   input logic                stat_wr,
   input logic                in_vld,
   input logic                in_is_wr,
   input logic [DATA_W/8-1:0] in_be,
   input logic                irq
);

   // R2: a bit may only appear in status if it was enabled, unless software toggled it
   assert_set_needs_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(stat_wr) |-> ((status & ~$past(status) & ~$past(enable)) == '0));

   // R4: without a status write, pending bits never clear
   assert_status_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(stat_wr) |-> (($past(status) & ~status) == '0));

   // R5: decoder off while enable is all zeros
   assert_off_when_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(enable) == '0 && !$past(stat_wr)) |-> $stable(status));

   // R7: partial writes never touch status
   assert_partial_be_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(in_vld) && $past(in_is_wr) && !(&$past(in_be)) && !$past(stat_wr))
      |-> $stable(status));

   // R8: reads never touch status
   assert_read_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(in_vld) && !$past(in_is_wr) && !$past(stat_wr)) |-> $stable(status));

   if (!IRQ_REG) begin : g_comb_checks
      // R3: fully masked or empty status keeps the line low
      assert_irq_low_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (mask == '1) |-> !irq);
      assert_irq_low_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (status == '0) |-> !irq);
   end

endmodule

bind msi_doorbell_irq msi_doorbell_irq_chk #(
   .DATA_W (DATA_W),
   .NUM_VEC(NUM_VEC),
   .IRQ_REG(IRQ_REG)
) chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .status  (status_q),
   .enable  (enable),
   .mask    (mask),
   .stat_wr (stat_wr),
   .in_vld  (in_vld_i),
   .in_is_wr(in_is_wr_i),
   .in_be   (in_be_i),
   .irq     (irq_o)
);

// File: tb/msi_doorbell_irq_tb.sv
module msi_doorbell_irq_tb_top;

   localparam logic [11:0] A_LO   = 12'h820;
   localparam logic [11:0] A_HI   = 12'h824;
   localparam logic [11:0] A_EN   = 12'h828;
   localparam logic [11:0] A_MASK = 12'h82C;
   localparam logic [11:0] A_STAT = 12'h830;
   localparam logic [63:0] DB     = 64'h0000_0001_F000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        in_vld = 1'b0;
   logic        in_is_wr = 1'b0;
   logic [63:0] in_addr = '0;
   logic [3:0]  in_be = '0;
   logic [31:0] in_data = '0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   msi_doorbell_irq dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .reg_wr_i   (reg_wr),
      .reg_addr_i (reg_addr),
      .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata),
      .in_vld_i   (in_vld),
      .in_is_wr_i (in_is_wr),
      .in_addr_i  (in_addr),
      .in_be_i    (in_be),
      .in_data_i  (in_data),
      .irq_o      (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus(input logic [63:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic is_wr);
      @(negedge clk);
      in_vld = 1'b1; in_is_wr = is_wr; in_addr = a; in_data = d; in_be = be;
      @(negedge clk);
      in_vld = 1'b0;
   endtask

   task automatic t_reset;
      rd_check("R10 base lo", A_LO, 32'h0);
      rd_check("R10 base hi", A_HI, 32'h0);
      rd_check("R10 enable", A_EN, 32'h0);
      rd_check("R10 mask", A_MASK, 32'h0);
      rd_check("R10 status", A_STAT, 32'h0);
      check("R10 irq", 32'(irq), 32'h0);
   endtask

   task automatic t_regmap;
      wr(A_LO, DB[31:0]);
      wr(A_HI, DB[63:32]);
      wr(A_MASK, 32'h0000_00F0);
      wr(A_EN, 32'hFFFF_FFFF);
      rd_check("R1 base lo", A_LO, 32'hF000_0000);
      rd_check("R1 base hi", A_HI, 32'h0000_0001);
      rd_check("R1 mask", A_MASK, 32'h0000_00F0);
      rd_check("R1 enable", A_EN, 32'hFFFF_FFFF);
      rd_check("R1 unmapped", 12'h834, 32'h0);
      rd_check("R1 unaligned", 12'h822, 32'h0);
      wr(A_MASK, 32'h0);
   endtask

   task automatic t_capture;
      wr(A_EN, 32'h0000_000F);
      bus(DB, 32'd3, 4'hF, 1'b1);
      check("R3 irq after capture", 32'(irq), 32'h1);
      rd_check("R2 enabled vector", A_STAT, 32'h0000_0008);
      bus(DB, 32'd5, 4'hF, 1'b1);
      rd_check("R2 disabled vector", A_STAT, 32'h0000_0008);
   endtask

   task automatic t_toggle;
      wr(A_STAT, 32'h0000_0008);
      check("R3 irq drops on clear", 32'(irq), 32'h0);
      rd_check("R4 clear", A_STAT, 32'h0);
      wr(A_STAT, 32'h0000_0001);
      rd_check("R4 invert zero bit", A_STAT, 32'h0000_0001);
      check("R3 irq from toggle", 32'(irq), 32'h1);
      wr(A_STAT, 32'h0000_0001);
      rd_check("R4 invert back", A_STAT, 32'h0);
   endtask

   task automatic t_mask;
      wr(A_MASK, 32'h0000_0008);
      bus(DB, 32'd3, 4'hF, 1'b1);
      check("R3 masked irq", 32'(irq), 32'h0);
      rd_check("R3 masked status", A_STAT, 32'h0000_0008);
      wr(A_MASK, 32'h0);
      check("R3 unmask irq", 32'(irq), 32'h1);
      wr(A_MASK, 32'h0000_0008);
      check("R3 remask irq", 32'(irq), 32'h0);
      wr(A_MASK, 32'h0);
      wr(A_STAT, 32'h0000_0008);
   endtask

   task automatic t_window;
      wr(A_EN, 32'hFFFF_FFFF);
      bus(DB,              32'd0, 4'hF, 1'b1);
      bus(DB + 64'd3,      32'd1, 4'hF, 1'b1);
      bus(DB + 64'd4,      32'd2, 4'hF, 1'b1);
      bus(DB - 64'd1,      32'd3, 4'hF, 1'b1);
      bus(64'h0000_0002_F000_0000, 32'd4, 4'hF, 1'b1);
      rd_check("R6 window edges", A_STAT, 32'h0000_0003);
      wr(A_STAT, 32'h0000_0003);
   endtask

   task automatic t_be;
      bus(DB, 32'd6, 4'h7, 1'b1);
      bus(DB, 32'd6, 4'h0, 1'b1);
      rd_check("R7 partial write", A_STAT, 32'h0);
      check("R7 irq", 32'(irq), 32'h0);
   endtask

   task automatic t_read;
      bus(DB, 32'd7, 4'hF, 1'b0);
      rd_check("R8 read ignored", A_STAT, 32'h0);
   endtask

   task automatic t_vec;
      bus(DB, 32'd32, 4'hF, 1'b1);
      bus(DB, 32'h100, 4'hF, 1'b1);
      rd_check("R9 out of range", A_STAT, 32'h0);
      bus(DB, 32'd31, 4'hF, 1'b1);
      rd_check("R9 top vector", A_STAT, 32'h8000_0000);
      wr(A_STAT, 32'h8000_0000);
   endtask

   task automatic t_off;
      wr(A_EN, 32'h0);
      bus(DB, 32'd0, 4'hF, 1'b1);
      rd_check("R5 decoder off", A_STAT, 32'h0);
      check("R5 irq", 32'(irq), 32'h0);
   endtask

   task automatic t_simul;
      wr(A_EN, 32'hFFFF_FFFF);
      bus(DB, 32'd0, 4'hF, 1'b1);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h1;
      in_vld = 1'b1; in_is_wr = 1'b1; in_addr = DB; in_be = 4'hF; in_data = 32'd2;
      @(negedge clk);
      reg_wr = 1'b0; in_vld = 1'b0;
      rd_check("R11 toggle plus other capture", A_STAT, 32'h0000_0004);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h4;
      in_vld = 1'b1; in_is_wr = 1'b1; in_addr = DB; in_be = 4'hF; in_data = 32'd2;
      @(negedge clk);
      reg_wr = 1'b0; in_vld = 1'b0;
      rd_check("R11 capture beats clear", A_STAT, 32'h0000_0004);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_capture();
      t_toggle();
      t_mask();
      t_window();
      t_be();
      t_read();
      t_vec();
      t_off();
      t_simul();
      finish_run();
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule